// File: doc/BRIEF.md
# Double-Press Reset Mode Detector

This block watches the active-low push-button reset line of a small host computer. It separates a single press from two presses made in quick succession. A single press resets the host with every memory region that the DIP switches enable. A double press also forces the low 3K RAM region and the upper expansion blocks off, so the host boots with only its built-in memory.

The raw button passes through a two-flop synchronizer and then a tick-counted debounce filter. The first press edge opens a fixed-length one-shot window. While the window is idle, that edge clears a two-stage press register. The register shifts a constant 1 on each debounced press edge, never on a release edge. Both mode flags come from its second stage. The mode flags therefore change about one debounce time after a button goes down, while the host is still held in reset, and never after release, when the host is already sizing its RAM. Each final region enable is the DIP enable gated by the inverse of its mode flag.

Top module: `dtap_mode_detect`

## Requirements
- R1: After the synchronous reset, both mode flags are 0 and every region enable equals its DIP enable.
- R2: The raw button goes through two synchronizer flops. The debounced level changes only when the synchronized input has disagreed with it for DB_MS consecutive tick pulses, so a low glitch shorter than that is never counted as a press.
- R3: Each debounced falling edge (press) shifts a 1 into the first stage of the two-stage press register, and moves the old first stage into the second stage.
- R4: A falling edge of the synchronized button while the window is idle starts the one-shot window. The window then stays active for WIN_MS tick pulses.
- R5: The press register is cleared only by a synchronized falling edge that arrives while the window is idle. An edge that arrives while the window is active leaves the register unchanged.
- R6: Both mode flags equal the second stage of the press register, so they go high together on the debounced edge of a second counted press.
- R7: Release edges never change the mode flags. After a double press, the flags are already high while the button is still held, and they stay unchanged after release.
- R8: A single press that starts with the window idle leaves both mode flags at 0, and all region enables equal to the DIP enables.
- R9: low_en equals dip_low_en AND NOT mode_low_off. Each bit of blk_en equals the matching dip_blk_en bit AND NOT mode_blk_off. A DIP change shows on the enables in the same cycle.
- R10: The window counts as active through the cycle of its last tick. A press edge that lands in that same cycle does not clear the register. An edge one cycle later does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| btn_raw_n | input | 1 | Raw push-button reset, low while pressed |
| dip_low_en | input | 1 | DIP enable for the low 3K region |
| dip_blk_en | input | NBLK | DIP enables for the upper expansion blocks |
| mode_low_off | output | 1 | Double-press flag that forces the low 3K region off |
| mode_blk_off | output | 1 | Double-press flag that forces the upper blocks off |
| low_en | output | 1 | Final low 3K region enable |
| blk_en | output | NBLK | Final upper block enables |

## Verification
The closest collision in this block is between expiry of the one-shot window and a new press edge that wants to clear the press register. Both can resolve in the same clock edge. The bench provokes this collision by following its own window model and dropping the button exactly three cycles before the predicted expiry edge, and then one cycle later. The first case must keep both flags high once the new press has been debounced; the second must clear them. A cycle-accurate reference model, kept in the bench, judges every cycle of both cases against the output ports.

// File: rtl/dtap_pkg.sv
package dtap_pkg;

    localparam int DEF_DB_MS  = 40;
    localparam int DEF_WIN_MS = 350;
    localparam int DEF_NBLK   = 3;

    typedef logic [1:0] press_sr_t;

    typedef struct packed {
        logic low_off;
        logic blk_off;
    } mode_t;

    typedef struct packed {
        logic level;
        logic press_start;
    } btn_sync_t;

    function automatic press_sr_t shift_one(input press_sr_t sr);
        return {sr[0], 1'b1};
    endfunction

    function automatic mode_t mode_from(input press_sr_t sr);
        mode_t m;
        m.low_off = sr[1];
        m.blk_off = sr[1];
        return m;
    endfunction

endpackage

// File: rtl/dtap_sync.sv
module dtap_sync
    import dtap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      din_n,
    output btn_sync_t sync_o
);
    logic [2:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= 3'b111;
        else     pipe <= {pipe[1:0], din_n};
    end

    always_comb begin
        sync_o.level       = pipe[1];
        sync_o.press_start = pipe[2] & ~pipe[1];
    end
endmodule

// File: rtl/dtap_debounce.sv
module dtap_debounce #(
    parameter int DB_MS = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic level_in,
    output logic level_out,
    output logic fall_pulse
);
    localparam int CW = (DB_MS > 1) ? $clog2(DB_MS + 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(DB_MS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_out  <= 1'b1;
            cnt        <= '0;
            fall_pulse <= 1'b0;
        end else begin
            fall_pulse <= 1'b0;
            if (level_in == level_out) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == LAST) begin
                    level_out  <= level_in;
                    cnt        <= '0;
                    fall_pulse <= ~level_in;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dtap_window.sv
module dtap_window #(
    parameter int WIN_MS = 350
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic press_start,
    output logic active,
    output logic clr_req
);
    localparam int WCW = (WIN_MS > 1) ? $clog2(WIN_MS + 1) : 1;
    localparam logic [WCW-1:0] LAST = WCW'(WIN_MS - 1);

    logic [WCW-1:0] wc;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            wc     <= '0;
        end else if (!active) begin
            if (press_start) begin
                active <= 1'b1;
                wc     <= '0;
            end
        end else if (tick) begin
            if (wc == LAST) active <= 1'b0;
            else            wc     <= wc + 1'b1;
        end
    end

    assign clr_req = press_start & ~active;
endmodule

// File: rtl/dtap_mode_detect.sv
module dtap_mode_detect
    import dtap_pkg::*;
#(
    parameter int DB_MS  = DEF_DB_MS,
    parameter int WIN_MS = DEF_WIN_MS,
    parameter int NBLK   = DEF_NBLK
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ms_tick,
    input  logic            btn_raw_n,
    input  logic            dip_low_en,
    input  logic [NBLK-1:0] dip_blk_en,
    output logic            mode_low_off,
    output logic            mode_blk_off,
    output logic            low_en,
    output logic [NBLK-1:0] blk_en
);
    btn_sync_t sync_s;
    logic      deb_level;
    logic      deb_fall;
    logic      win_act;
    logic      clr_req;
    press_sr_t sr;
    mode_t     mode;

    dtap_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .din_n  (btn_raw_n),
        .sync_o (sync_s)
    );

    dtap_debounce #(.DB_MS(DB_MS)) u_deb (
        .clk        (clk),
        .rst        (rst),
        .tick       (ms_tick),
        .level_in   (sync_s.level),
        .level_out  (deb_level),
        .fall_pulse (deb_fall)
    );

    dtap_window #(.WIN_MS(WIN_MS)) u_win (
        .clk         (clk),
        .rst         (rst),
        .tick        (ms_tick),
        .press_start (sync_s.press_start),
        .active      (win_act),
        .clr_req     (clr_req)
    );

    always_ff @(posedge clk) begin
        if (rst)           sr <= '0;
        else if (clr_req)  sr <= '0;
        else if (deb_fall) sr <= shift_one(sr);
    end

    assign mode         = mode_from(sr);
    assign mode_low_off = mode.low_off;
    assign mode_blk_off = mode.blk_off;
    assign low_en       = dip_low_en & ~mode.low_off;

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        assign blk_en[g] = dip_blk_en[g] & ~mode.blk_off;
    end
endmodule

// File: rtl/dtap_checker.sv
module dtap_checker (
    input logic clk,
    input logic rst,
    input logic ms_tick,
    input logic press_start,
    input logic win_act,
    input logic clr_req,
    input logic deb_level,
    input logic deb_fall,
    input logic mode_low_off,
    input logic mode_blk_off
);
    p_level_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (deb_level != $past(deb_level)) |-> $past(ms_tick));

    p_window_from_edge_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(win_act) |-> $past(press_start));

    p_drop_needs_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(mode_low_off) |-> $past(clr_req));

    p_rise_needs_press_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_low_off) |-> $past(deb_fall));

    p_flags_agree_r6: assert property (@(posedge clk) disable iff (rst)
        mode_low_off == mode_blk_off);

    p_active_edge_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (win_act && press_start) |=> $stable(mode_low_off));
endmodule

bind dtap_mode_detect dtap_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .ms_tick      (ms_tick),
    .press_start  (sync_s.press_start),
    .win_act      (win_act),
    .clr_req      (clr_req),
    .deb_level    (deb_level),
    .deb_fall     (deb_fall),
    .mode_low_off (mode_low_off),
    .mode_blk_off (mode_blk_off)
);

// File: tb/dtap_mode_detect_bench.sv
module dtap_mode_detect_bench;
    localparam int DBT  = 4;
    localparam int WINT = 60;
    localparam int NB   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ms_tick = 1'b0;
    logic btn = 1'b1;
    logic dip_low = 1'b1;
    logic [NB-1:0] dip_blk = '1;
    logic mlo, mbo, len;
    logic [NB-1:0] ben;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int tick_div = 1;
    int tcnt = 0;

    always #4 clk = ~clk;

    dtap_mode_detect #(.DB_MS(DBT), .WIN_MS(WINT), .NBLK(NB)) u_dtap_mode_detect (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .btn_raw_n(btn),
        .dip_low_en(dip_low), .dip_blk_en(dip_blk),
        .mode_low_off(mlo), .mode_blk_off(mbo), .low_en(len), .blk_en(ben)
    );

    // reference model built from the requirements
    logic m1, m2, m3, mfilt, mfallp, mact;
    int mcnt, mwc;
    logic [1:0] mst;
    logic m_ps, m_clr;
    assign m_ps  = m3 & ~m2;
    assign m_clr = m_ps & ~mact;

    always @(posedge clk) begin
        if (rst) begin
            m1 <= 1; m2 <= 1; m3 <= 1; mfilt <= 1; mfallp <= 0;
            mact <= 0; mcnt <= 0; mwc <= 0; mst <= 0;
        end else begin
            if (m_clr) mst <= 2'b00;
            else if (mfallp) mst <= {mst[0], 1'b1};
            if (!mact) begin
                if (m_ps) begin mact <= 1; mwc <= 0; end
            end else if (ms_tick) begin
                if (mwc == WINT - 1) mact <= 0; else mwc <= mwc + 1;
            end
            mfallp <= 0;
            if (m2 == mfilt) mcnt <= 0;
            else if (ms_tick) begin
                if (mcnt == DBT - 1) begin
                    mfilt <= m2; mcnt <= 0; mfallp <= ~m2;
                end else mcnt <= mcnt + 1;
            end
            m1 <= btn; m2 <= m1; m3 <= m2;
        end
    end

    always @(posedge clk) begin
        #2;
        ms_tick = (tcnt == 0);
        tcnt = (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R6 flags vs model", {6'b0, mlo, mbo}, {6'b0, mst[1], mst[1]});
            chk("R9 enables vs model", {4'b0, len, ben},
                {4'b0, dip_low & ~mst[1], dip_blk & {NB{~mst[1]}}});
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic press(input int lo, input int hi);
        btn = 0; cyc(lo); btn = 1; cyc(hi);
    endtask

    task automatic check_modes(input string tag, input logic exp);
        @(negedge clk);
        chk(tag, {6'b0, mlo, mbo}, {6'b0, exp, exp});
        @(posedge clk); #2;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        cyc(5);
        rst = 0;
        @(negedge clk);
        chk("R1 reset flags", {6'b0, mlo, mbo}, 8'h00);
        chk("R1 reset enables", {4'b0, len, ben}, {4'b0, dip_low, dip_blk});
        @(posedge clk); #2;

        // R9: DIP changes show at once while flags are 0
        dip_low = 0; dip_blk = 3'b101;
        @(negedge clk);
        chk("R9 dip follow", {4'b0, len, ben}, 8'b0000_0101);
        @(posedge clk); #2;
        dip_low = 1; dip_blk = '1;

        // R2: press then short glitch inside window must not count
        press(10, 4);
        press(2, 20);
        check_modes("R2 glitch ignored", 1'b0);
        cyc(WINT + 5);

        // R3/R6/R7: double press, flags high while still held
        press(10, 4);
        btn = 0; cyc(DBT + 6);
        check_modes("R7 flags high before release", 1'b1);
        @(negedge clk);
        chk("R9 enables forced off", {4'b0, len, ben}, 8'h00);
        chk("R3 second stage set", {7'b0, mbo}, 8'h01);
        @(posedge clk); #2;
        btn = 1; cyc(DBT + 8);
        check_modes("R7 release keeps flags", 1'b1);

        // R5: press inside window does not clear
        press(10, 4);
        check_modes("R5 in-window press no clear", 1'b1);

        // R10: edge landing on the expiry cycle is blocked
        while (!(mact && mwc == WINT - 3)) cyc(1);
        press(10, DBT + 8);
        check_modes("R10 edge on expiry blocked", 1'b1);

        // R4/R8: single press with idle window clears, second inside reopens
        press(10, DBT + 8);
        check_modes("R8 single press clears", 1'b0);
        press(10, DBT + 8);
        check_modes("R4 second press in window", 1'b1);

        // R10: edge one cycle after expiry clears
        while (!(mact && mwc == WINT - 2)) cyc(1);
        press(10, DBT + 8);
        check_modes("R10 edge after expiry clears", 1'b0);
        @(negedge clk);
        chk("R8 enables back to DIP", {4'b0, len, ben}, {4'b0, dip_low, dip_blk});
        @(posedge clk); #2;

        // constrained random phase with fixed seed
        void'($urandom(32'd1977));
        for (int i = 0; i < 600; i++) begin
            if (i % 50 == 0) tick_div = 1 + ($urandom % 3);
            if ($urandom % 8 == 0) begin
                dip_low = $urandom;
                dip_blk = $urandom;
            end
            btn = ~btn;
            cyc(1 + ($urandom % (3 * DBT * tick_div + 6)));
        end
        btn = 1;
        cyc(WINT * 3 + 20);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule